// File: doc/BRIEF.md
# Camera Byte Stream Capture

This block receives the 8-bit pixel bus of a small CMOS image sensor in the sensor's own pixel clock domain. It uses the frame-sync and row-valid lines to follow the frame. It groups the incoming bytes into chroma-sharing pixel pairs: one blue-difference sample, one luma sample, one red-difference sample and a second luma sample. Each pair is tagged with its column-pair index and row index inside the frame.

Completed pairs cross into an unrelated system clock through a small FIFO whose pointers are Gray-coded. The system side takes them with a valid/ready handshake. A start-of-frame flag marks the first pair queued after each frame sync. A sticky overflow flag reports pairs lost because the FIFO was full.

A single active-low reset is synchronised into each clock domain. Both domains assert it at once and release it on their own clock edge.

Top module: `cam_pair_capture`

## Requirements
- R1: While reset is applied and right after it is released, `out_valid_o` is 0 and `overflow_o` is 0.
- R2: Bytes are sampled on the rising pixel clock edge while the row-valid input is 1. The byte on the first edge where row-valid is 1 after being 0 is taken as U. The following three bytes are taken as Y0, V and Y1, and the pattern then repeats. The four bytes of a group leave on `out_u_o`, `out_y0_o`, `out_v_o` and `out_y1_o`.
- R3: `out_col_o` is the index of the group within its row. It is 0 for the first group and rises by one for each completed group. Every new row starts again at 0.
- R4: `out_row_o` is 0 for the first row after a frame sync. It rises by one on every rising edge of row-valid, including rows that yield no complete group.
- R5: `out_sof_o` is 1 on the first group queued after a frame sync and 0 on every other group.
- R6: A group left incomplete when row-valid falls is discarded. The next row starts again at U.
- R7: Groups leave in arrival order. While `out_valid_o` is 1 and `out_ready_i` is 0, the valid signal and every output field hold steady.
- R8: When the FIFO (DEPTH entries) is full, each newly completed group is dropped. Queued groups are kept. `overflow_o` goes to 1 and stays at 1 until reset.
- R9: While the frame-sync input is 1, no group is assembled, even if row-valid is 1.
- R10: Bytes presented while row-valid is 0 produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n_i | input | 1 | Asynchronous active-low reset for both domains |
| pclk_i | input | 1 | Sensor pixel (byte) clock |
| vsync_i | input | 1 | Frame sync, active high |
| href_i | input | 1 | Row-valid, active high |
| pix_i | input | PIX_W | Sensor byte bus |
| clk_i | input | 1 | System clock |
| out_ready_i | input | 1 | Consumer accepts the current group |
| out_valid_o | output | 1 | A group is available |
| out_u_o | output | PIX_W | Blue-difference sample |
| out_y0_o | output | PIX_W | First luma sample |
| out_v_o | output | PIX_W | Red-difference sample |
| out_y1_o | output | PIX_W | Second luma sample |
| out_col_o | output | COL_W | Column-pair index in the row |
| out_row_o | output | ROW_W | Row index in the frame |
| out_sof_o | output | 1 | First group of a frame |
| overflow_o | output | 1 | Sticky: a group was dropped on a full FIFO |

## Verification
A byte phase that slips shows up within one group: every later group in the row has its four samples rotated or shifted. A wrong position counter appears on the next group as a column or row tag off by one, or one that fails to restart. A corrupted Gray pointer or a wrong full test shows up within a few system cycles after the pixel-side write, as a missing group, a repeated group or out-of-order data. A broken drop policy shows up as an overflow flag that never rises, or as queued groups overwritten by later ones.

// File: rtl/cam_cap_pkg.sv
package cam_cap_pkg;
  typedef enum logic [1:0] {
    PH_U  = 2'd0,
    PH_Y0 = 2'd1,
    PH_V  = 2'd2,
    PH_Y1 = 2'd3
  } phase_e;

  localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/cam_rst_sync.sv
module cam_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_o = stage_q[1];
endmodule

// File: rtl/cam_bit_sync.sv
module cam_bit_sync #(
  parameter int W      = 1,
  parameter int STAGES = cam_cap_pkg::SYNC_STAGES
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= '0;
        else if (s == 0) chain_q[s] <= d_i;
        else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/cam_byte_framer.sv
module cam_byte_framer
  import cam_cap_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int COL_W = 8,
  parameter int ROW_W = 9,
  localparam int DW   = 1 + ROW_W + COL_W + 4*PIX_W
) (
  input  logic             pclk,
  input  logic             prst_n,
  input  logic             vsync_i,
  input  logic             href_i,
  input  logic [PIX_W-1:0] pix_i,
  input  logic             full_i,
  output logic             wr_en_o,
  output logic [DW-1:0]    wr_data_o,
  output logic             overflow_o
);
  logic             href_q, href_n;
  phase_e           phase_q, phase_n, eff_ph;
  logic [COL_W-1:0] col_q, col_n;
  logic [ROW_W-1:0] row_q, row_n, seen_q, seen_n;
  logic             sof_q, sof_n, ovf_q, ovf_n;
  logic [PIX_W-1:0] u_q, y0_q, v_q;
  logic             u_en, y0_en, v_en, grp_done;

  always_comb begin
    href_n   = href_i;
    phase_n  = phase_q;
    col_n    = col_q;
    row_n    = row_q;
    seen_n   = seen_q;
    sof_n    = sof_q;
    ovf_n    = ovf_q;
    u_en     = 1'b0;
    y0_en    = 1'b0;
    v_en     = 1'b0;
    grp_done = 1'b0;
    eff_ph   = phase_q;
    if (vsync_i) begin
      phase_n = PH_U;
      col_n   = '0;
      row_n   = '0;
      seen_n  = '0;
      sof_n   = 1'b1;
    end else if (href_i) begin
      if (!href_q) begin
        eff_ph = PH_U;
        col_n  = '0;
        row_n  = seen_q;
        seen_n = seen_q + ROW_W'(1);
      end
      unique case (eff_ph)
        PH_U:  begin u_en  = 1'b1; phase_n = PH_Y0; end
        PH_Y0: begin y0_en = 1'b1; phase_n = PH_V;  end
        PH_V:  begin v_en  = 1'b1; phase_n = PH_Y1; end
        PH_Y1: begin
          grp_done = 1'b1;
          phase_n  = PH_U;
          col_n    = col_q + COL_W'(1);
        end
        default: phase_n = PH_U;
      endcase
      if (grp_done) begin
        if (full_i) ovf_n = 1'b1;
        else        sof_n = 1'b0;
      end
    end else begin
      phase_n = PH_U;
    end
  end

  always_ff @(posedge pclk or negedge prst_n) begin
    if (!prst_n) begin
      href_q  <= 1'b0;
      phase_q <= PH_U;
      col_q   <= '0;
      row_q   <= '0;
      seen_q  <= '0;
      sof_q   <= 1'b0;
      ovf_q   <= 1'b0;
      u_q     <= '0;
      y0_q    <= '0;
      v_q     <= '0;
    end else begin
      href_q  <= href_n;
      phase_q <= phase_n;
      col_q   <= col_n;
      row_q   <= row_n;
      seen_q  <= seen_n;
      sof_q   <= sof_n;
      ovf_q   <= ovf_n;
      if (u_en)  u_q  <= pix_i;
      if (y0_en) y0_q <= pix_i;
      if (v_en)  v_q  <= pix_i;
    end
  end

  assign wr_en_o    = grp_done && !full_i;
  assign wr_data_o  = {sof_q, row_q, col_q, u_q, y0_q, v_q, pix_i};
  assign overflow_o = ovf_q;

  // R9
  vsync_clears_phase_chk: assert property (@(posedge pclk) disable iff (!prst_n)
    vsync_i |=> (phase_q == PH_U));
  // R6
  phase_needs_row_chk: assert property (@(posedge pclk) disable iff (!prst_n)
    (phase_q != PH_U) |-> href_q);
  // R3
  col_restart_chk: assert property (@(posedge pclk) disable iff (!prst_n)
    (href_i && !href_q && !vsync_i) |=> (col_q == '0));
  // R8
  overflow_sticky_chk: assert property (@(posedge pclk) disable iff (!prst_n)
    ovf_q |=> ovf_q);
endmodule

// File: rtl/cam_async_fifo.sv
module cam_async_fifo #(
  parameter int DW    = 50,
  parameter int DEPTH = 4,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  output logic          full_o,
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          rd_en_i,
  output logic [DW-1:0] rd_data_o,
  output logic          empty_o
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW:0]   wbin_q, wbin_n, wgray_q, wgray_n, rq2;
  logic [AW:0]   rbin_q, rbin_n, rgray_q, rgray_n, wq2;
  logic          wr_go, rd_go;

  assign full_o  = (wgray_q == {~rq2[AW:AW-1], rq2[AW-2:0]});
  assign empty_o = (rgray_q == wq2);
  assign wr_go   = wr_en_i && !full_o;
  assign rd_go   = rd_en_i && !empty_o;

  always_comb begin
    wbin_n  = wbin_q + (AW+1)'(wr_go);
    wgray_n = wbin_n ^ (wbin_n >> 1);
    rbin_n  = rbin_q + (AW+1)'(rd_go);
    rgray_n = rbin_n ^ (rbin_n >> 1);
  end

  always_ff @(posedge wclk) begin
    if (wr_go) mem[wbin_q[AW-1:0]] <= wr_data_i;
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else begin
      wbin_q  <= wbin_n;
      wgray_q <= wgray_n;
    end
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin_q  <= '0;
      rgray_q <= '0;
    end else begin
      rbin_q  <= rbin_n;
      rgray_q <= rgray_n;
    end
  end

  cam_bit_sync #(.W(AW+1)) u_rptr_sync (
    .clk(wclk), .rst_n(wrst_n), .d_i(rgray_q), .q_o(rq2)
  );
  cam_bit_sync #(.W(AW+1)) u_wptr_sync (
    .clk(rclk), .rst_n(rrst_n), .d_i(wgray_q), .q_o(wq2)
  );

  assign rd_data_o = mem[rbin_q[AW-1:0]];

  // R8
  full_blocks_write_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
    (wr_en_i && full_o) |=> $stable(wgray_q));
endmodule

// File: rtl/cam_pair_capture.sv
module cam_pair_capture #(
  parameter int PIX_W       = 8,
  parameter int ACTIVE_PIX  = 356,
  parameter int ACTIVE_ROWS = 292,
  parameter int DEPTH       = 4,
  localparam int COL_W      = $clog2(ACTIVE_PIX/2),
  localparam int ROW_W      = $clog2(ACTIVE_ROWS)
) (
  input  logic             rst_n_i,
  input  logic             pclk_i,
  input  logic             vsync_i,
  input  logic             href_i,
  input  logic [PIX_W-1:0] pix_i,
  input  logic             clk_i,
  input  logic             out_ready_i,
  output logic             out_valid_o,
  output logic [PIX_W-1:0] out_u_o,
  output logic [PIX_W-1:0] out_y0_o,
  output logic [PIX_W-1:0] out_v_o,
  output logic [PIX_W-1:0] out_y1_o,
  output logic [COL_W-1:0] out_col_o,
  output logic [ROW_W-1:0] out_row_o,
  output logic             out_sof_o,
  output logic             overflow_o
);
  localparam int DW = 1 + ROW_W + COL_W + 4*PIX_W;

  logic          prst_n, srst_n;
  logic          wr_en, full, empty, ovf_p;
  logic [DW-1:0] wr_data, rd_data;

  cam_rst_sync u_prst (.clk(pclk_i), .arst_n(rst_n_i), .rst_n_o(prst_n));
  cam_rst_sync u_srst (.clk(clk_i),  .arst_n(rst_n_i), .rst_n_o(srst_n));

  cam_byte_framer #(.PIX_W(PIX_W), .COL_W(COL_W), .ROW_W(ROW_W)) u_framer (
    .pclk(pclk_i), .prst_n(prst_n), .vsync_i(vsync_i), .href_i(href_i),
    .pix_i(pix_i), .full_i(full), .wr_en_o(wr_en), .wr_data_o(wr_data),
    .overflow_o(ovf_p)
  );

  cam_async_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .wclk(pclk_i), .wrst_n(prst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .full_o(full), .rclk(clk_i), .rrst_n(srst_n),
    .rd_en_i(out_ready_i), .rd_data_o(rd_data), .empty_o(empty)
  );

  cam_bit_sync #(.W(1)) u_ovf_sync (
    .clk(clk_i), .rst_n(srst_n), .d_i(ovf_p), .q_o(overflow_o)
  );

  assign out_valid_o = !empty;
  assign {out_sof_o, out_row_o, out_col_o,
          out_u_o, out_y0_o, out_v_o, out_y1_o} = rd_data;

  // R7
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!srst_n)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(rd_data)));
endmodule

// File: tb/cam_pair_capture_test.sv
`timescale 1ns/1ps
module cam_pair_capture_test;
  logic rst_n, pclk, clk, vsync, href, ready;
  logic [7:0] pix;
  logic valid, sof, ovf;
  logic [7:0] u, y0, v, y1;
  logic [7:0] col;
  logic [8:0] row;

  int checks = 0, fails = 0;
  int wr = 0, rd = 0, row_b = 0;
  bit sof_b = 0;
  logic [7:0] e_u [256], e_y0 [256], e_v [256], e_y1 [256];
  int e_col [256], e_row [256];
  bit e_sof [256];

  // {vsync before row, expected complete groups, bytes in row}
  localparam logic [15:0] VEC [10] = '{
    {1'b1, 7'd2, 8'd8},  {1'b0, 7'd3, 8'd12}, {1'b0, 7'd1, 8'd6},
    {1'b0, 7'd1, 8'd4},  {1'b0, 7'd0, 8'd3},  {1'b1, 7'd4, 8'd16},
    {1'b0, 7'd5, 8'd22}, {1'b0, 7'd2, 8'd9},  {1'b0, 7'd6, 8'd24},
    {1'b0, 7'd3, 8'd13}
  };

  cam_pair_capture uut (
    .rst_n_i(rst_n), .pclk_i(pclk), .vsync_i(vsync), .href_i(href),
    .pix_i(pix), .clk_i(clk), .out_ready_i(ready), .out_valid_o(valid),
    .out_u_o(u), .out_y0_o(y0), .out_v_o(v), .out_y1_o(y1),
    .out_col_o(col), .out_row_o(row), .out_sof_o(sof), .overflow_o(ovf)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;
  initial pclk = 0;
  always #28 pclk = ~pclk;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && valid && ready) begin
      if (rd >= wr) chk(0, "R10 unexpected group", rd, wr);
      else begin
        chk(u == e_u[rd],   "R2 U",  u,  e_u[rd]);
        chk(y0 == e_y0[rd], "R2 Y0", y0, e_y0[rd]);
        chk(v == e_v[rd],   "R2 V",  v,  e_v[rd]);
        chk(y1 == e_y1[rd], "R2 Y1", y1, e_y1[rd]);
        chk(int'(col) == e_col[rd], "R3 column", col, e_col[rd]);
        chk(int'(row) == e_row[rd], "R4 row", row, e_row[rd]);
        chk(sof == e_sof[rd], "R5 sof", sof, e_sof[rd]);
      end
      rd++;
    end
  end

  task automatic frame_sync();
    @(negedge pclk); vsync = 1;
    repeat (2) @(negedge pclk);
    vsync = 0; row_b = 0; sof_b = 1;
  endtask

  task automatic send_row(int len, int base, int keep);
    for (int g = 0; g < keep; g++) begin
      e_u[wr] = 8'(base + 4*g);     e_y0[wr] = 8'(base + 4*g + 1);
      e_v[wr] = 8'(base + 4*g + 2); e_y1[wr] = 8'(base + 4*g + 3);
      e_col[wr] = g; e_row[wr] = row_b; e_sof[wr] = sof_b;
      sof_b = 0; wr++;
    end
    for (int k = 0; k < len; k++) begin
      @(negedge pclk); href = 1; pix = 8'(base + k);
    end
    @(negedge pclk); href = 0; pix = 8'hA5;
    for (int k = 0; k < 3; k++) begin @(negedge pclk); pix = ~pix; end // R10 noise
    row_b++;
  endtask

  task automatic drain_check(string req);
    repeat (150) @(negedge clk);
    chk(rd == wr, req, rd, wr);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 0; vsync = 0; href = 0; pix = 0;
    @(posedge clk); #1 ready = 1;
    repeat (20) @(negedge clk);
    chk(valid == 0, "R1 valid in reset", valid, 0);
    chk(ovf == 0, "R1 overflow in reset", ovf, 0);
    rst_n = 1;
    repeat (20) @(negedge clk);
    chk(valid == 0, "R1 valid after reset", valid, 0);
    chk(ovf == 0, "R1 overflow after reset", ovf, 0);

    for (int i = 0; i < 10; i++) begin
      if (VEC[i][15]) frame_sync();
      send_row(int'(VEC[i][7:0]), 16 * i + 3, int'(VEC[i][14:8]));
    end
    drain_check("R7 all groups delivered in order");
    chk(ovf == 0, "R8 no overflow without stall", ovf, 0);

    // R9: row-valid during frame sync assembles nothing; next row is row 0
    @(negedge pclk); vsync = 1;
    for (int k = 0; k < 8; k++) begin @(negedge pclk); href = 1; pix = 8'(k); end
    @(negedge pclk); vsync = 0; href = 0;
    row_b = 0; sof_b = 1;
    repeat (3) @(negedge pclk);
    drain_check("R9 nothing during frame sync");
    send_row(8, 8'h40, 2);
    drain_check("R9 row after sync");

    // R8: stall consumer, overfill
    @(posedge clk); #1 ready = 0;
    frame_sync();
    send_row(40, 8'h80, 4);
    repeat (50) @(negedge clk);
    chk(ovf == 1, "R8 overflow raised", ovf, 1);
    chk(valid == 1, "R7 valid held under stall", valid, 1);
    chk(u == 8'h80, "R7 head held under stall", u, 8'h80);
    @(posedge clk); #1 ready = 1;
    drain_check("R8 only queued groups kept");
    chk(ovf == 1, "R8 overflow sticky", ovf, 1);

    rst_n = 0;
    repeat (10) @(negedge clk);
    rst_n = 1;
    repeat (20) @(negedge clk);
    chk(ovf == 0, "R1 overflow cleared by reset", ovf, 0);
    chk(valid == 0, "R1 valid after second reset", valid, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule